// File: doc/BRIEF.md
# Register frame cache controller

This block keeps track of a small on-chip pool of local register frames used by a processor's procedure call and return path. Each call claims a new physical frame slot and each return releases the current one. The frames form a circular window: a head pointer marks the oldest resident frame, and a count gives how many frames are resident. When a call finds the window too full, the oldest frames are written out to a memory save area before the new frame is claimed. When a return leaves no resident caller frame, the most recently written-out frame is read back. A flush request writes out every resident frame, so memory then holds the whole call history.

Code running at low priority can be held to fewer resident frames than the pool has. This keeps free slots in reserve for urgent interrupt handlers. A 3-bit limit taken from a configuration word sets how many frames are kept back from such code. The limit is applied only when a call claims a frame. The contents of a newly claimed frame are left undefined, so a call does no clearing. Until a flush has run, the memory save area and the cached frames need not agree.

A requester raises one of the call, return or flush requests and holds it until `done`. While a spill or fill is under way, requests stall.

Top module: `reg_frame_cache`

## Requirements
- R1: After reset, `occupancy` is 0, `busy` is 0, `mem_valid` is 0 and the head pointer is slot 0, so the first spill targets slot 0.
- R2: Code is critical only when `interrupted` is 1 and `cur_prio` is 28 or more. Critical code may hold all 8 frames: eight critical calls from empty complete with no memory traffic and `occupancy` 8.
- R3: The limit is `cfg_word[10:8]`. Non-critical code may hold at most 8 minus the limit frames. A call that finds `occupancy` at or above its allowance first spills oldest frames, repeatedly if needed, until `occupancy` is below the allowance, and then claims the new frame.
- R4: A limit of 0 reserves nothing: non-critical code may also fill all 8 frames without a spill.
- R5: A limit of 7 leaves non-critical code one frame: every such call with at least one resident frame spills down to zero, and the call then ends with `occupancy` 1.
- R6: The limit and priority act only on a call. Changing them while idle, or issuing a return, never starts a spill and never changes `occupancy`.
- R7: Spills write the oldest resident slot, and the head then advances by one modulo 8. `top_slot` equals head plus `occupancy` minus 1, modulo 8.
- R8: A return with `occupancy` of 2 or more completes in the cycle it is seen, lowers `occupancy` by 1 and causes no memory traffic.
- R9: A return with `occupancy` of 0 or 1 drops the current frame and then fills the slot just below the head, which holds the most recently spilled frame. The head moves back by one and `occupancy` becomes 1.
- R10: A flush spills every resident frame, oldest first, and leaves `occupancy` at 0. A flush with nothing resident completes at once.
- R11: A spill or fill is offered with `mem_valid` (`mem_write` 1 for a spill, 0 for a fill, slot on `mem_slot`). It moves on a cycle with `mem_valid` and `mem_ready` both high. Until then, `mem_valid`, `mem_write` and `mem_slot` hold steady. `mem_valid` never rises in the cycle a request is first seen.
- R12: `done` is high, combinationally, in the cycle whose clock edge finishes the operation. While `busy`, it rises only together with `mem_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| call_req | input | 1 | Claim a new frame; held until `done` |
| ret_req | input | 1 | Release the current frame; held until `done` |
| flush_req | input | 1 | Write out all resident frames; held until `done` |
| interrupted | input | 1 | Current code runs in the interrupted state |
| cur_prio | input | 5 | Current process priority |
| cfg_word | input | 16 | Configuration word; bits 10:8 carry the limit |
| mem_valid | output | 1 | A spill or fill is offered |
| mem_ready | input | 1 | Memory accepts the offered transfer |
| mem_write | output | 1 | 1 = spill to memory, 0 = fill from memory |
| mem_slot | output | 3 | Physical frame slot being transferred |
| done | output | 1 | Requested operation finishes at this edge |
| busy | output | 1 | A spill or fill sequence is in progress |
| occupancy | output | 4 | Number of resident frames |
| top_slot | output | 3 | Physical slot of the newest resident frame |

## Verification
The assertions rely on three properties of the inputs. At most one request is raised at a time. A request stays high until `done`. `interrupted`, `cur_prio` and `cfg_word` stay constant while an operation runs. They also rely on software never returning past the outermost frame. The bench changes the priority and configuration inputs only between operations, together with a new request on a falling edge. It raises a single request and keeps it until the expected completion edge. It tracks call depth so that a return is issued only while a caller frame exists in the cache or in memory. `mem_ready` is randomised, so transfers are exercised both with and without back-pressure.

// File: rtl/rfc_pkg.sv
package rfc_pkg;

  typedef enum logic [2:0] {
    PT_HOLD,
    PT_PUSH,
    PT_POP,
    PT_SPILL,
    PT_SPILL_PUSH,
    PT_FILL
  } ptr_op_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_CALL_SPILL,
    SQ_FILL,
    SQ_FLUSH
  } seq_state_e;

  // Critical code: interrupted and at or above the threshold priority.
  function automatic logic is_critical(logic intr, int unsigned prio,
                                       int unsigned threshold);
    return intr && (prio >= threshold);
  endfunction

  // Number of frames the requesting code may hold after a call.
  function automatic int unsigned frame_allowance(int unsigned frames,
                                                  logic crit,
                                                  int unsigned limit);
    return crit ? frames : frames - limit;
  endfunction

endpackage

// File: rtl/rfc_policy.sv
module rfc_policy #(
  parameter int FRAMES    = 8,
  parameter int PRIO_W    = 5,
  parameter int CRIT_PRIO = 28,
  parameter int CFG_W     = 16,
  parameter int LIM_LSB   = 8,
  parameter int LIM_W     = 3,
  parameter int CNT_W     = 4
) (
  input  logic              interrupted,
  input  logic [PRIO_W-1:0] cur_prio,
  input  logic [CFG_W-1:0]  cfg_word,
  output logic              critical,
  output logic [CNT_W-1:0]  allowance
);
  logic [LIM_W-1:0] limit;

  assign limit     = cfg_word[LIM_LSB +: LIM_W];
  assign critical  = rfc_pkg::is_critical(interrupted, int'(cur_prio), CRIT_PRIO);
  assign allowance = CNT_W'(rfc_pkg::frame_allowance(FRAMES, critical, int'(limit)));
endmodule

// File: rtl/rfc_ptrs.sv
module rfc_ptrs #(
  parameter int FRAMES = 8,
  parameter int IDX_W  = 3,
  parameter int CNT_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  rfc_pkg::ptr_op_e op,
  output logic [IDX_W-1:0] head,
  output logic [CNT_W-1:0] count,
  output logic [IDX_W-1:0] top_slot,
  output logic [IDX_W-1:0] fill_slot
);
  import rfc_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head  <= '0;
      count <= '0;
    end else begin
      case (op)
        PT_PUSH:       count <= count + CNT_W'(1);
        PT_POP:        if (count != '0) count <= count - CNT_W'(1);
        PT_SPILL: begin
          head  <= head + IDX_W'(1);
          count <= count - CNT_W'(1);
        end
        PT_SPILL_PUSH: head <= head + IDX_W'(1);
        PT_FILL: begin
          head  <= head - IDX_W'(1);
          count <= count + CNT_W'(1);
        end
        default: ;
      endcase
    end
  end

  assign top_slot  = head + count[IDX_W-1:0] - IDX_W'(1);
  assign fill_slot = head - IDX_W'(1);

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(FRAMES));
  // R3
  push_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op == PT_PUSH |-> count < CNT_W'(FRAMES));
  // R7
  spill_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == PT_SPILL || op == PT_SPILL_PUSH) |-> count != '0);
  // R9
  fill_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op == PT_FILL |-> count == '0);
endmodule

// File: rtl/rfc_seq.sv
module rfc_seq #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             call_req,
  input  logic             ret_req,
  input  logic             flush_req,
  input  logic [CNT_W-1:0] allowance,
  input  logic [CNT_W-1:0] count,
  input  logic             mem_ready,
  output rfc_pkg::ptr_op_e op,
  output logic             mem_valid,
  output logic             mem_write,
  output logic             done,
  output logic             busy
);
  import rfc_pkg::*;

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cap_q, cap_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cap_q   <= '0;
    end else begin
      state_q <= state_d;
      cap_q   <= cap_d;
    end
  end

  always_comb begin
    state_d = state_q;
    cap_d   = cap_q;
    op      = PT_HOLD;
    done    = 1'b0;
    case (state_q)
      SQ_IDLE: begin
        if (call_req) begin
          if (count >= allowance) begin
            state_d = SQ_CALL_SPILL;
            cap_d   = allowance;
          end else begin
            op   = PT_PUSH;
            done = 1'b1;
          end
        end else if (ret_req) begin
          op = PT_POP;
          if (count >= CNT_W'(2)) done = 1'b1;
          else                    state_d = SQ_FILL;
        end else if (flush_req) begin
          if (count == '0) done = 1'b1;
          else             state_d = SQ_FLUSH;
        end
      end
      SQ_CALL_SPILL: begin
        if (mem_ready) begin
          if (count <= cap_q) begin
            op      = PT_SPILL_PUSH;
            done    = 1'b1;
            state_d = SQ_IDLE;
          end else begin
            op = PT_SPILL;
          end
        end
      end
      SQ_FILL: begin
        if (mem_ready) begin
          op      = PT_FILL;
          done    = 1'b1;
          state_d = SQ_IDLE;
        end
      end
      default: begin
        if (mem_ready) begin
          op = PT_SPILL;
          if (count == CNT_W'(1)) begin
            done    = 1'b1;
            state_d = SQ_IDLE;
          end
        end
      end
    endcase
  end

  assign busy      = (state_q != SQ_IDLE);
  assign mem_valid = busy;
  assign mem_write = (state_q != SQ_FILL);

  // R11
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_write));
  // R12
  stall_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && done |-> mem_ready);
  // R11
  no_early_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && (call_req || ret_req || flush_req) |-> !mem_valid);
endmodule

// File: rtl/reg_frame_cache.sv
module reg_frame_cache #(
  parameter int FRAMES    = 8,
  parameter int PRIO_W    = 5,
  parameter int CRIT_PRIO = 28,
  parameter int CFG_W     = 16,
  parameter int LIM_LSB   = 8,
  parameter int LIM_W     = 3,
  localparam int IDX_W    = $clog2(FRAMES),
  localparam int CNT_W    = $clog2(FRAMES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              call_req,
  input  logic              ret_req,
  input  logic              flush_req,
  input  logic              interrupted,
  input  logic [PRIO_W-1:0] cur_prio,
  input  logic [CFG_W-1:0]  cfg_word,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [IDX_W-1:0]  mem_slot,
  output logic              done,
  output logic              busy,
  output logic [CNT_W-1:0]  occupancy,
  output logic [IDX_W-1:0]  top_slot
);
  rfc_pkg::ptr_op_e ptr_op;
  logic             critical;
  logic [CNT_W-1:0] allowance;
  logic [IDX_W-1:0] head;
  logic [IDX_W-1:0] fill_slot;

  rfc_policy #(
    .FRAMES(FRAMES), .PRIO_W(PRIO_W), .CRIT_PRIO(CRIT_PRIO),
    .CFG_W(CFG_W), .LIM_LSB(LIM_LSB), .LIM_W(LIM_W), .CNT_W(CNT_W)
  ) u_policy (
    .interrupted(interrupted),
    .cur_prio   (cur_prio),
    .cfg_word   (cfg_word),
    .critical   (critical),
    .allowance  (allowance)
  );

  rfc_seq #(.CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .call_req  (call_req),
    .ret_req   (ret_req),
    .flush_req (flush_req),
    .allowance (allowance),
    .count     (occupancy),
    .mem_ready (mem_ready),
    .op        (ptr_op),
    .mem_valid (mem_valid),
    .mem_write (mem_write),
    .done      (done),
    .busy      (busy)
  );

  rfc_ptrs #(.FRAMES(FRAMES), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ptrs (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (ptr_op),
    .head     (head),
    .count    (occupancy),
    .top_slot (top_slot),
    .fill_slot(fill_slot)
  );

  assign mem_slot = mem_write ? head : fill_slot;

  // R3
  allowance_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    allowance >= CNT_W'(1) && allowance <= CNT_W'(FRAMES));
  // R2
  critical_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    critical |-> allowance == CNT_W'(FRAMES));
  // R3
  call_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && call_req |=> occupancy <= $past(allowance));
  // R10
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && flush_req && !call_req && !ret_req |=> occupancy == '0);
  // R9
  fill_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_write && mem_ready |=> occupancy == CNT_W'(1));
  // R11
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> $stable(mem_slot));
endmodule

// File: tb/test_reg_frame_cache.sv
module test_reg_frame_cache;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       call_req = 1'b0, ret_req = 1'b0, flush_req = 1'b0;
  logic       interrupted = 1'b0;
  logic [4:0] cur_prio = '0;
  logic [15:0] cfg_word = '0;
  logic       mem_valid, mem_ready = 1'b0, mem_write, done, busy;
  logic [2:0] mem_slot, top_slot;
  logic [3:0] occupancy;

  int checks = 0, failures = 0;
  int mcnt = 0, mhead = 0, depth = 1;

  always #10 clk = ~clk;

  reg_frame_cache i_reg_frame_cache (
    .clk(clk), .rst_n(rst_n), .call_req(call_req), .ret_req(ret_req),
    .flush_req(flush_req), .interrupted(interrupted), .cur_prio(cur_prio),
    .cfg_word(cfg_word), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_write(mem_write), .mem_slot(mem_slot), .done(done), .busy(busy),
    .occupancy(occupancy), .top_slot(top_slot)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Frames available to the current code: urgent handlers get the whole pool.
  function automatic int exp_allow();
    int lim = int'(cfg_word[10:8]);
    if (!interrupted || cur_prio < 5'd28) return 8 - lim;
    return 8;
  endfunction

  task automatic set_ctx(input bit intr, input int prio, input int lim);
    interrupted = intr;
    cur_prio    = 5'(prio);
    cfg_word    = 16'($urandom);
    cfg_word[10:8] = 3'(lim);
  endtask

  // kind: 0 call, 1 return, 2 flush
  task automatic run_op(input int kind, input int ready_pct);
    int allow = 0;
    bit need = 0, fin = 0, exp_w;
    int exp_slot;
    string tag = (kind == 0) ? "R3" : (kind == 1) ? "R9" : "R10";
    @(negedge clk);
    call_req = (kind == 0); ret_req = (kind == 1); flush_req = (kind == 2);
    for (int cyc = 0; cyc < 300 && !fin; cyc++) begin
      if (cyc > 0) @(negedge clk);
      mem_ready = ($urandom_range(1, 100) <= ready_pct);
      #1;
      if (cyc == 0) begin
        allow = exp_allow();
        case (kind)
          0: need = (mcnt >= allow);
          1: need = (mcnt < 2);
          default: need = (mcnt > 0);
        endcase
        check(mem_valid == 1'b0, "R11 valid on accept", int'(mem_valid), 0);
        check(done == !need, (kind == 1 && !need) ? "R8 done" : "R12 done", int'(done), int'(!need));
        if (!need) begin
          if (kind == 0) mcnt++;
          if (kind == 1) mcnt--;
          fin = 1;
        end else if (kind == 1) mcnt = 0;
      end else begin
        exp_w = (kind != 1);
        exp_slot = exp_w ? mhead : ((mhead + 7) % 8);
        check(mem_valid == 1'b1, "R11 valid", int'(mem_valid), 1);
        check(mem_write == exp_w, "R11 direction", int'(mem_write), int'(exp_w));
        check(int'(mem_slot) == exp_slot, exp_w ? "R7 spill slot" : "R9 fill slot",
              int'(mem_slot), exp_slot);
        if (mem_ready) begin
          if (exp_w) begin mhead = (mhead + 1) % 8; mcnt--; end
          else begin mhead = (mhead + 7) % 8; mcnt++; end
          case (kind)
            0: fin = (mcnt < allow);
            1: fin = 1;
            default: fin = (mcnt == 0);
          endcase
          if (kind == 0 && fin) mcnt++;
        end
        check(done == fin, {tag, " completion"}, int'(done), int'(fin));
      end
    end
    if (!fin) check(1'b0, {tag, " timeout"}, 0, 1);
    if (kind == 0) depth++;
    if (kind == 1) depth--;
    @(posedge clk);
    @(negedge clk);
    call_req = 0; ret_req = 0; flush_req = 0; mem_ready = 0;
    #1;
    check(busy == 1'b0, "R12 idle after done", int'(busy), 0);
    check(int'(occupancy) == mcnt, {tag, " occupancy"}, int'(occupancy), mcnt);
    if (mcnt > 0)
      check(int'(top_slot) == (mhead + mcnt + 7) % 8, "R7 top slot", int'(top_slot),
            (mhead + mcnt + 7) % 8);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    #1;
    check(occupancy == 4'd0, "R1 occupancy", int'(occupancy), 0);
    check(busy == 1'b0, "R1 busy", int'(busy), 0);
    check(mem_valid == 1'b0, "R1 mem_valid", int'(mem_valid), 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(occupancy == 4'd0 && mem_valid == 1'b0, "R1 after release", int'(occupancy), 0);

    // R2: critical code fills the whole pool, then one more call spills once
    set_ctx(1, 30, 5);
    for (int i = 0; i < 8; i++) run_op(0, 70);
    check(occupancy == 4'd8, "R2 full pool", int'(occupancy), 8);
    run_op(0, 50);
    check(mhead == 1, "R1 R7 first spill from slot 0", mhead, 1);

    // R3: non-critical limit 3 forces several spills down to the allowance
    set_ctx(1, 20, 3);
    run_op(0, 60);
    check(occupancy == 4'd5, "R3 multi spill", int'(occupancy), 5);

    // R6: changing the limit while idle does nothing
    set_ctx(0, 3, 7);
    repeat (5) begin
      @(negedge clk); #1;
      check(mem_valid == 1'b0, "R6 no spill on config", int'(mem_valid), 0);
    end
    check(occupancy == 4'd5, "R6 occupancy kept", int'(occupancy), 5);
    run_op(1, 60);
    check(occupancy == 4'd4, "R6 return under limit 7", int'(occupancy), 4);

    // R5: limit 7 leaves a single frame to non-critical code
    run_op(0, 60);
    check(occupancy == 4'd1, "R5 limit seven", int'(occupancy), 1);
    run_op(0, 100);
    check(occupancy == 4'd1, "R5 repeat", int'(occupancy), 1);

    // R9: return from a single resident frame fills
    run_op(1, 40);
    check(occupancy == 4'd1, "R9 fill", int'(occupancy), 1);

    // R4: limit 0 gives all frames to non-critical code
    set_ctx(0, 0, 0);
    for (int i = 0; i < 7; i++) run_op(0, 80);
    check(occupancy == 4'd8, "R4 limit zero", int'(occupancy), 8);

    // R8: ordinary return
    run_op(1, 80);
    check(occupancy == 4'd7, "R8 return", int'(occupancy), 7);

    // R10: flush, then flush with nothing resident
    run_op(2, 50);
    check(occupancy == 4'd0, "R10 flush", int'(occupancy), 0);
    run_op(2, 50);
    check(occupancy == 4'd0, "R10 empty flush", int'(occupancy), 0);
    run_op(1, 50);

    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      int r = $urandom_range(0, 9);
      set_ctx(1'($urandom_range(0, 1)), $urandom_range(0, 31), $urandom_range(0, 7));
      if (r < 5 || (r < 9 && depth < 2)) run_op(0, 60);
      else if (r < 9) run_op(1, 60);
      else run_op(2, 60);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule